// File: doc/BRIEF.md
# Hardware Thread Select Controller

This block chooses which of several hardware thread contexts feeds the next instruction into one shared pipeline. A thread is eligible in a cycle when its ready flag is high and its stall flag is low. The block has two run-time modes. In fine-grained mode it picks a new eligible thread on every cycle in round-robin order.

In coarse-grained mode it keeps one thread, called the current thread, and switches only when a long-latency stall event is raised for it. On a switch it requests a one-cycle pipeline flush and then withholds issue for a fixed refill window. A preferred thread can be enabled. When it is eligible, it overrides the round-robin choice.

All outputs are combinational from the registered pointer, the refill state and the present inputs. The pointer holds the last granted thread in fine-grained mode and the current thread in coarse-grained mode.

Top module: `thr_sel_ctrl`

## Requirements
- R1: After reset the pointer holds the highest thread ID. With `mode_i`=0 (fine-grained) and every thread eligible, the first grant is thread 0. With no thread eligible, `issue_vld_o` and `flush_o` are 0.
- R2: In fine-grained mode (`mode_i`=0), the grant goes to the first eligible thread, searching upward and wrapping from the thread after the last one granted. `tid_o` is the binary thread ID, and `issue_vld_o` is 1.
- R3: A thread whose `rdy_i` bit is 0 or whose `stall_i` bit is 1 is never granted. Bit i of these buses belongs to thread i.
- R4: When no thread is eligible in fine-grained mode, `issue_vld_o` is 0, `tid_o` shows the last granted thread, and the next search still starts after that thread.
- R5: When `pref_en_i` is 1 and thread `pref_id_i` is a candidate, it is granted instead of the round-robin choice. This applies to every fine-grained grant and to the choice of the new thread at a coarse-grained switch.
- R6: In coarse-grained mode (`mode_i`=1) and outside a refill window, `tid_o` is the current thread and `issue_vld_o` equals that thread's eligibility. The current thread does not change while `long_stall_i` is 0.
- R7: In coarse-grained mode, a `long_stall_i` pulse outside a refill window, while some other thread is eligible, produces a switch. In that same cycle `flush_o` is 1 for exactly one cycle, `issue_vld_o` is 0 and `tid_o` is still the old thread. From the next cycle the new thread is current.
- R8: After the flush cycle, `issue_vld_o` stays 0 for `REFILL_CYC` cycles (default 4) while `tid_o` shows the new thread. Issue from the new thread starts on the following cycle.
- R9: `long_stall_i` has no effect in fine-grained mode or during a refill window. `flush_o` stays 0 in both cases.
- R10: In coarse-grained mode, a `long_stall_i` pulse while no other thread is eligible causes no switch and no flush, and the current thread stays.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 1 | 0 = fine-grained, 1 = coarse-grained |
| rdy_i | input | NUM_THR | Per-thread ready flag |
| stall_i | input | NUM_THR | Per-thread stall flag |
| long_stall_i | input | 1 | Long-latency stall event for the current thread |
| pref_en_i | input | 1 | Enables the preferred-thread override |
| pref_id_i | input | TW | Preferred thread ID |
| tid_o | output | TW | Selected thread ID |
| issue_vld_o | output | 1 | Issue strobe for the selected thread |
| flush_o | output | 1 | One-cycle pipeline flush request |

## Verification
The preferred-thread override and the coarse-grained switch decision can fall in the same cycle. The bench provokes this by raising `long_stall_i` with the preference set to a thread that round-robin order would not pick next. It then expects the flush pulse with the old `tid_o`, followed by the preferred thread as the new current thread through the whole refill window.

A second collision is a long-stall pulse that arrives inside a refill window. The bench expects this pulse to leave `flush_o` low and the window length unchanged.

// File: rtl/thr_sel_pkg.sv
package thr_sel_pkg;
  typedef enum logic {
    MODE_FINE   = 1'b0,
    MODE_COARSE = 1'b1
  } sel_mode_e;
endpackage

// File: rtl/thr_rr_arb.sv
// Round-robin pick with preferred-thread override.
module thr_rr_arb #(
  parameter int NUM_THR = 4,
  localparam int TW = $clog2(NUM_THR)
) (
  input  logic [NUM_THR-1:0] req_i,
  input  logic [TW-1:0]      base_i,
  input  logic               pref_en_i,
  input  logic [TW-1:0]      pref_id_i,
  output logic [TW-1:0]      gnt_o,
  output logic               vld_o
);
  logic [TW-1:0] rr_id;
  logic          rr_hit;

  always_comb begin
    rr_id  = base_i;
    rr_hit = 1'b0;
    for (int k = 0; k < NUM_THR; k++) begin
      logic [TW-1:0] idx;
      idx = base_i + TW'(k + 1);
      if (!rr_hit && req_i[idx]) begin
        rr_id  = idx;
        rr_hit = 1'b1;
      end
    end
  end

  always_comb begin
    if (pref_en_i && req_i[pref_id_i]) gnt_o = pref_id_i;
    else                               gnt_o = rr_id;
    vld_o = rr_hit;
  end
endmodule

// File: rtl/thr_refill_ctr.sv
// Refill window counter; busy for REFILL_CYC cycles after start.
module thr_refill_ctr #(
  parameter int REFILL_CYC = 4,
  localparam int CW = $clog2(REFILL_CYC + 1) < 1 ? 1 : $clog2(REFILL_CYC + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic clr_i,
  output logic busy_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (clr_i)          cnt_q <= '0;
    else if (start_i)        cnt_q <= CW'(REFILL_CYC);
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/thr_sel_ctrl.sv
module thr_sel_ctrl
  import thr_sel_pkg::*;
#(
  parameter int NUM_THR    = 4,
  parameter int REFILL_CYC = 4,
  localparam int TW = $clog2(NUM_THR)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               mode_i,
  input  logic [NUM_THR-1:0] rdy_i,
  input  logic [NUM_THR-1:0] stall_i,
  input  logic               long_stall_i,
  input  logic               pref_en_i,
  input  logic [TW-1:0]      pref_id_i,
  output logic [TW-1:0]      tid_o,
  output logic               issue_vld_o,
  output logic               flush_o
);
  sel_mode_e          mode;
  logic [NUM_THR-1:0] elig;
  logic [NUM_THR-1:0] others;
  logic [TW-1:0]      ptr_q;
  logic [TW-1:0]      fine_gnt, sw_gnt;
  logic               fine_vld, sw_vld;
  logic               refill_busy;
  logic               do_switch;

  assign mode   = sel_mode_e'(mode_i);
  assign elig   = rdy_i & ~stall_i;
  assign others = elig & ~(NUM_THR'(1) << ptr_q);

  thr_rr_arb #(.NUM_THR(NUM_THR)) u_arb_fine (
    .req_i     (elig),
    .base_i    (ptr_q),
    .pref_en_i (pref_en_i),
    .pref_id_i (pref_id_i),
    .gnt_o     (fine_gnt),
    .vld_o     (fine_vld)
  );

  thr_rr_arb #(.NUM_THR(NUM_THR)) u_arb_switch (
    .req_i     (others),
    .base_i    (ptr_q),
    .pref_en_i (pref_en_i),
    .pref_id_i (pref_id_i),
    .gnt_o     (sw_gnt),
    .vld_o     (sw_vld)
  );

  assign do_switch = (mode == MODE_COARSE) && !refill_busy && long_stall_i && sw_vld;

  thr_refill_ctr #(.REFILL_CYC(REFILL_CYC)) u_refill (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (do_switch),
    .clr_i   (mode == MODE_FINE),
    .busy_o  (refill_busy)
  );

  always_comb begin
    flush_o     = 1'b0;
    tid_o       = ptr_q;
    issue_vld_o = 1'b0;
    if (mode == MODE_FINE) begin
      tid_o       = fine_gnt;
      issue_vld_o = fine_vld;
    end else if (do_switch) begin
      flush_o = 1'b1;
    end else if (!refill_busy) begin
      issue_vld_o = elig[ptr_q];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                               ptr_q <= TW'(NUM_THR - 1);
    else if (mode == MODE_FINE && fine_vld)    ptr_q <= fine_gnt;
    else if (do_switch)                        ptr_q <= sw_gnt;
  end
endmodule

// File: rtl/thr_sel_ctrl_chk.sv
module thr_sel_ctrl_chk #(
  parameter int NUM_THR    = 4,
  parameter int REFILL_CYC = 4,
  localparam int TW = $clog2(NUM_THR)
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               mode_i,
  input logic [NUM_THR-1:0] rdy_i,
  input logic [NUM_THR-1:0] stall_i,
  input logic               long_stall_i,
  input logic               pref_en_i,
  input logic [TW-1:0]      pref_id_i,
  input logic [TW-1:0]      tid_o,
  input logic               issue_vld_o,
  input logic               flush_o
);
  logic [NUM_THR-1:0] elig;
  logic [31:0]        win_q;
  logic               live_q;

  assign elig = rdy_i & ~stall_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q  <= '0;
      live_q <= 1'b0;
    end else begin
      live_q <= 1'b1;
      if (!mode_i)         win_q <= '0;
      else if (flush_o)    win_q <= 32'(REFILL_CYC);
      else if (win_q != 0) win_q <= win_q - 1;
    end
  end

  assert_flush_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |=> !flush_o);
  assert_flush_no_issue_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |-> !issue_vld_o);
  assert_no_fine_flush_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |-> mode_i);
  assert_refill_gap_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i && win_q != 0) |-> (!issue_vld_o && !flush_o));
  assert_idle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (elig == '0) |-> !issue_vld_o);
  assert_grant_eligible_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_vld_o |-> elig[tid_o]);
  assert_pref_wins_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_i && pref_en_i && elig[pref_id_i]) |-> (issue_vld_o && tid_o == pref_id_i));
  assert_coarse_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live_q && mode_i && $past(mode_i) && issue_vld_o && $past(issue_vld_o)) |-> $stable(tid_o));
endmodule

bind thr_sel_ctrl thr_sel_ctrl_chk #(.NUM_THR(NUM_THR), .REFILL_CYC(REFILL_CYC)) u_chk (.*);

// File: tb/sim_thr_sel_ctrl.sv
`timescale 1ns/1ps
module sim_thr_sel_ctrl;
  localparam int NT = 4;
  localparam int TW = 2;

  typedef struct {
    logic [TW-1:0] tid;
    logic          vld;
    logic          fl;
    string         req;
  } exp_t;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          mode_i = 1'b0;
  logic [NT-1:0] rdy_i = '0;
  logic [NT-1:0] stall_i = '0;
  logic          long_stall_i = 1'b0;
  logic          pref_en_i = 1'b0;
  logic [TW-1:0] pref_id_i = '0;
  logic [TW-1:0] tid_o;
  logic          issue_vld_o;
  logic          flush_o;

  exp_t sb[$];
  int   n_chk = 0;
  int   n_bad = 0;
  bit   done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  thr_sel_ctrl #(.NUM_THR(NT), .REFILL_CYC(4)) u0 (.*);

  task automatic step(input logic m, input logic [NT-1:0] r, input logic [NT-1:0] s,
                      input logic ls, input logic pe, input logic [TW-1:0] pid,
                      input logic [TW-1:0] et, input logic ev, input logic ef, input string req);
    exp_t e;
    @(posedge clk_i); #1;
    mode_i = m; rdy_i = r; stall_i = s; long_stall_i = ls; pref_en_i = pe; pref_id_i = pid;
    e.tid = et; e.vld = ev; e.fl = ef; e.req = req;
    sb.push_back(e);
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk_i);
      if (sb.size() != 0) begin
        exp_t e;
        e = sb.pop_front();
        n_chk++;
        if (tid_o !== e.tid || issue_vld_o !== e.vld || flush_o !== e.fl) begin
          n_bad++;
          $display("FAIL %s: got tid=%0d vld=%0b flush=%0b exp tid=%0d vld=%0b flush=%0b",
                   e.req, tid_o, issue_vld_o, flush_o, e.tid, e.vld, e.fl);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (5000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    // R1 reset state, nothing eligible
    step(0, 4'h0, 4'h0, 0, 0, 0, 2'd3, 0, 0, "R1");
    // R1 / R2 round robin over all threads
    step(0, 4'hF, 4'h0, 0, 0, 0, 2'd0, 1, 0, "R1");
    step(0, 4'hF, 4'h0, 0, 0, 0, 2'd1, 1, 0, "R2");
    step(0, 4'hF, 4'h0, 0, 0, 0, 2'd2, 1, 0, "R2");
    step(0, 4'hF, 4'h0, 0, 0, 0, 2'd3, 1, 0, "R2");
    step(0, 4'hF, 4'h0, 0, 0, 0, 2'd0, 1, 0, "R2");
    // R3 skip thread 1 (stalled) and thread 2 (not ready)
    step(0, 4'hB, 4'h2, 0, 0, 0, 2'd3, 1, 0, "R3");
    step(0, 4'hB, 4'h2, 0, 0, 0, 2'd0, 1, 0, "R3");
    step(0, 4'hB, 4'h2, 0, 0, 0, 2'd3, 1, 0, "R3");
    // R4 none eligible, pointer holds at 3
    step(0, 4'h0, 4'h0, 0, 0, 0, 2'd3, 0, 0, "R4");
    step(0, 4'hF, 4'h0, 0, 0, 0, 2'd0, 1, 0, "R4");
    // R5 preferred thread 2
    step(0, 4'hF, 4'h0, 0, 1, 2, 2'd2, 1, 0, "R5");
    step(0, 4'hF, 4'h0, 0, 1, 2, 2'd2, 1, 0, "R5");
    step(0, 4'hF, 4'h4, 0, 1, 2, 2'd3, 1, 0, "R5");
    // R9 long stall ignored in fine mode
    step(0, 4'hF, 4'h0, 1, 0, 0, 2'd0, 1, 0, "R9");
    // R6 coarse mode stays on thread 0
    step(1, 4'hF, 4'h0, 0, 0, 0, 2'd0, 1, 0, "R6");
    step(1, 4'hF, 4'h0, 0, 0, 0, 2'd0, 1, 0, "R6");
    step(1, 4'hE, 4'h0, 0, 0, 0, 2'd0, 0, 0, "R6");
    step(1, 4'hF, 4'h0, 0, 0, 0, 2'd0, 1, 0, "R6");
    // R7 switch from 0 to 1
    step(1, 4'hF, 4'h1, 1, 0, 0, 2'd0, 0, 1, "R7");
    // R8 refill window, R9 long stall inside window ignored
    step(1, 4'hF, 4'h1, 0, 0, 0, 2'd1, 0, 0, "R8");
    step(1, 4'hF, 4'h1, 1, 0, 0, 2'd1, 0, 0, "R9");
    step(1, 4'hF, 4'h1, 0, 0, 0, 2'd1, 0, 0, "R8");
    step(1, 4'hF, 4'h1, 0, 0, 0, 2'd1, 0, 0, "R8");
    step(1, 4'hF, 4'h1, 0, 0, 0, 2'd1, 1, 0, "R8");
    // R10 no other eligible thread, no switch
    step(1, 4'h2, 4'h0, 1, 0, 0, 2'd1, 1, 0, "R10");
    step(1, 4'h2, 4'h0, 0, 0, 0, 2'd1, 1, 0, "R10");
    // R5 preferred thread 3 wins at switch time over round-robin pick 2
    step(1, 4'hF, 4'h2, 1, 1, 3, 2'd1, 0, 1, "R5");
    step(1, 4'hF, 4'h0, 0, 0, 0, 2'd3, 0, 0, "R5");
    step(1, 4'hF, 4'h0, 0, 0, 0, 2'd3, 0, 0, "R8");
    step(1, 4'hF, 4'h0, 0, 0, 0, 2'd3, 0, 0, "R8");
    step(1, 4'hF, 4'h0, 0, 0, 0, 2'd3, 0, 0, "R8");
    step(1, 4'hF, 4'h0, 0, 0, 0, 2'd3, 1, 0, "R8");
    // back to fine mode, search after thread 3
    step(0, 4'hF, 4'h0, 0, 0, 0, 2'd0, 1, 0, "R2");
    repeat (2) @(negedge clk_i);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule